// File: doc/BRIEF.md
# Per-CPU GPIO Interrupt Router

This block takes the pending-interrupt flags of a 32-pin GPIO bank and distributes them to several processor interrupt lines. The bank is organised as four ports of eight pins each. Pin `8*p + b` is bit `b` of port `p`. Every processor owns four byte-wide enable masks, one for each port. A set mask bit lets the matching pin reach that processor, and a clear bit blocks it. Each processor output is the registered OR of the pin status vector ANDed with that processor's masks. How the status flags are produced (edge detection and acknowledgement) is handled elsewhere, and the flags arrive here as a plain input vector.

The masks sit in a small byte-addressed window. The byte for processor `c` and port `p` is at offset `4*c + lane`. In normal order the lane is `p`. When the `REVERSED` parameter is set, the lane is `3 - p`, which matches the byte layout of a bank whose port order is swapped. Software is expected to open every mask fully, and the reset value does the same. The window decodes `2**ADDR_W` bytes. Offsets past the last processor hold no storage.

Top module: `gpio_cpu_irq_router`

## Requirements
- R1: After reset every mask byte reads 0xFF and every processor output is 0.
- R2: Each `cpu_irq[c]` is a register. The value present on it in the cycle after a clock edge equals the OR over all pins of (`pin_status` AND the mask of processor `c`) sampled at that edge, so it rises one clock after an enabled status bit goes high and falls one clock after the last enabled bit clears.
- R3: With `REVERSED` = 0, the mask byte for processor `c`, port `p` is at byte offset `4*c + p`, and bit `b` of that byte gates pin `8*p + b`.
- R4: With `REVERSED` = 1, the mask byte for processor `c`, port `p` is at byte offset `4*c + (3 - p)`, and bit `b` of that byte still gates pin `8*p + b`.
- R5: A write (`wr_en` high at a clock edge) changes only the one addressed mask byte. All other bytes keep their values.
- R6: `rd_data` is combinational from `acc_addr` and returns the stored mask byte at that offset, including a value written at an earlier edge.
- R7: Offsets at or above `4*NUM_CPUS` read as 0x00, and writes to them change no mask byte and no routing.
- R8: A 0 in a mask bit blocks that pin from that processor, a 1 routes it, and each processor's masks act independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_status | input | 32 | Pending interrupt flags, pin 8*p+b is port p bit b |
| wr_en | input | 1 | Mask byte write strobe |
| acc_addr | input | ADDR_W | Byte offset into the mask window |
| wr_data | input | 8 | Mask byte to write |
| rd_data | output | 8 | Mask byte at `acc_addr`, zero outside the populated range |
| cpu_irq | output | NUM_CPUS | Registered interrupt line per processor |

## Verification
Reads are due in the same cycle as the address: the bench drives `acc_addr` on the falling edge and samples `rd_data` one time unit later. A write takes effect at the next rising edge, so readback happens only after that edge. Each `cpu_irq` bit lags `pin_status` by one register. The bench drives a new status on the falling edge, confirms that the output still holds the previous result before the rising edge, and then samples the new result on the following falling edge. Normal and reversed instances run side by side, and a model indexed by port predicts every read and every routing result.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
    localparam int PORTS      = 4;
    localparam int PORT_PINS  = 8;
    localparam int BANK_PINS  = PORTS * PORT_PINS;
    localparam int LANE_W     = $clog2(PORTS);

    typedef logic [PORT_PINS-1:0] mask_byte_t;
    typedef logic [LANE_W-1:0]    port_idx_t;

    typedef struct packed {
        logic      hit;
        port_idx_t port;
    } slot_t;

    // Byte lane inside a processor's group maps to a port index.
    function automatic port_idx_t lane_to_port(input port_idx_t lane, input logic rev);
        return rev ? port_idx_t'(PORTS - 1) - lane : lane;
    endfunction
endpackage

// File: rtl/gcr_addr_decode.sv
module gcr_addr_decode
    import gcr_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int ADDR_W   = 4,
    parameter bit REVERSED = 1'b0,
    localparam int CPU_W   = ADDR_W - LANE_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CPU_W-1:0]  cpu_sel,
    output slot_t             slot
);
    port_idx_t lane;

    always_comb begin
        lane      = addr[LANE_W-1:0];
        cpu_sel   = addr[ADDR_W-1:LANE_W];
        slot.port = lane_to_port(lane, REVERSED);
        slot.hit  = int'(cpu_sel) < NUM_CPUS;
    end
endmodule

// File: rtl/gcr_mask_bank.sv
module gcr_mask_bank
    import gcr_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int CPU_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [CPU_W-1:0]              cpu_sel,
    input  slot_t                         slot,
    input  mask_byte_t                    wr_data,
    output mask_byte_t                    rd_data,
    output logic [NUM_CPUS*BANK_PINS-1:0] mask_flat
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            mask_byte_t byte_q;
            logic       sel;

            assign sel = slot.hit && (cpu_sel == CPU_W'(c)) && (slot.port == port_idx_t'(p));

            always_ff @(posedge clk) begin
                if (rst) begin
                    byte_q <= '1;
                end else if (wr_en && sel) begin
                    byte_q <= wr_data;
                end
            end

            assign mask_flat[c*BANK_PINS + p*PORT_PINS +: PORT_PINS] = byte_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int p = 0; p < PORTS; p++) begin
                if (slot.hit && cpu_sel == CPU_W'(c) && slot.port == port_idx_t'(p)) begin
                    rd_data = mask_flat[c*BANK_PINS + p*PORT_PINS +: PORT_PINS];
                end
            end
        end
    end
endmodule

// File: rtl/gcr_irq_reduce.sv
module gcr_irq_reduce
    import gcr_pkg::*;
#(
    parameter int NUM_CPUS = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [BANK_PINS-1:0]          pin_status,
    input  logic [NUM_CPUS*BANK_PINS-1:0] mask_flat,
    output logic [NUM_CPUS-1:0]           cpu_irq
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [BANK_PINS-1:0] gated;

        assign gated = pin_status & mask_flat[c*BANK_PINS +: BANK_PINS];

        always_ff @(posedge clk) begin
            if (rst) begin
                cpu_irq[c] <= 1'b0;
            end else begin
                cpu_irq[c] <= |gated;
            end
        end
    end
endmodule

// File: rtl/gpio_cpu_irq_router.sv
module gpio_cpu_irq_router
    import gcr_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int ADDR_W   = 4,
    parameter bit REVERSED = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [31:0]          pin_status,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [7:0]           wr_data,
    output logic [7:0]           rd_data,
    output logic [NUM_CPUS-1:0]  cpu_irq
);
    localparam int CPU_W = ADDR_W - LANE_W;

    logic [CPU_W-1:0]              cpu_sel;
    slot_t                         slot;
    logic [NUM_CPUS*BANK_PINS-1:0] mask_flat;

    gcr_addr_decode #(
        .NUM_CPUS (NUM_CPUS),
        .ADDR_W   (ADDR_W),
        .REVERSED (REVERSED)
    ) u_dec (
        .addr    (acc_addr),
        .cpu_sel (cpu_sel),
        .slot    (slot)
    );

    gcr_mask_bank #(
        .NUM_CPUS (NUM_CPUS),
        .CPU_W    (CPU_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .cpu_sel   (cpu_sel),
        .slot      (slot),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .mask_flat (mask_flat)
    );

    gcr_irq_reduce #(
        .NUM_CPUS (NUM_CPUS)
    ) u_red (
        .clk        (clk),
        .rst        (rst),
        .pin_status (pin_status),
        .mask_flat  (mask_flat),
        .cpu_irq    (cpu_irq)
    );
endmodule

// File: rtl/gcr_checker.sv
module gcr_checker #(
    parameter int NUM_CPUS = 2,
    parameter int ADDR_W   = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [31:0]            pin_status,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      acc_addr,
    input logic [7:0]             rd_data,
    input logic [NUM_CPUS-1:0]    cpu_irq,
    input logic [NUM_CPUS*32-1:0] mask_flat
);
    localparam int NBYTES = NUM_CPUS * 4;

    logic [NUM_CPUS*32-1:0] mask_prev;
    logic [NBYTES-1:0]      byte_changed;
    logic                   out_of_range;

    always_ff @(posedge clk) mask_prev <= mask_flat;

    for (genvar k = 0; k < NBYTES; k++) begin : g_diff
        assign byte_changed[k] = mask_flat[8*k +: 8] != mask_prev[8*k +: 8];
    end

    assign out_of_range = int'(acc_addr) >= NBYTES;

    // R2: a silent status vector leaves every line low next cycle
    a_r2_quiet_low: assert property (@(posedge clk) disable iff (rst)
        (pin_status == '0) |=> (cpu_irq == '0));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_route
        // R2 / R8: an enabled pending pin raises the line one clock later
        a_r2_enabled_rises: assert property (@(posedge clk) disable iff (rst)
            ((pin_status & mask_flat[c*32 +: 32]) != '0) |=> cpu_irq[c]);
    end

    // R5: at most one mask byte changes per cycle
    a_r5_one_byte: assert property (@(posedge clk) disable iff (rst)
        $countones(byte_changed) <= 1);

    // R5: no write, no mask change
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_flat));

    // R7: writes beyond the last processor leave masks untouched
    a_r7_wr_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && out_of_range) |=> $stable(mask_flat));

    // R7: unpopulated offsets read as zero
    a_r7_rd_zero: assert property (@(posedge clk) disable iff (rst)
        out_of_range |-> (rd_data == 8'h00));
endmodule

bind gpio_cpu_irq_router gcr_checker #(
    .NUM_CPUS (NUM_CPUS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_status (pin_status),
    .wr_en      (wr_en),
    .acc_addr   (acc_addr),
    .rd_data    (rd_data),
    .cpu_irq    (cpu_irq),
    .mask_flat  (mask_flat)
);

// File: tb/gpio_cpu_irq_router_bench.sv
module gpio_cpu_irq_router_bench;
    localparam int CLK_P    = 10;
    localparam int NCPU     = 2;
    localparam int AW       = 4;
    localparam int NADDR    = 1 << AW;
    localparam int WATCHDOG = 50000;

    logic            clk = 1'b0;
    logic            rst;
    logic [31:0]     pin_status;
    logic            wr_en;
    logic [AW-1:0]   acc_addr;
    logic [7:0]      wr_data;
    logic [7:0]      rd_n, rd_r;
    logic [NCPU-1:0] irq_n, irq_r;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // model: em[inst][cpu][port], inst 0 = normal, 1 = reversed
    logic [7:0] em [2][NCPU][4];

    always #(CLK_P/2) clk = ~clk;

    gpio_cpu_irq_router #(.NUM_CPUS(NCPU), .ADDR_W(AW), .REVERSED(1'b0)) u_gpio_cpu_irq_router (
        .clk(clk), .rst(rst), .pin_status(pin_status), .wr_en(wr_en),
        .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_n), .cpu_irq(irq_n));

    gpio_cpu_irq_router #(.NUM_CPUS(NCPU), .ADDR_W(AW), .REVERSED(1'b1)) u_gpio_cpu_irq_router_rev (
        .clk(clk), .rst(rst), .pin_status(pin_status), .wr_en(wr_en),
        .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_r), .cpu_irq(irq_r));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int port_of(input int inst, input int lane);
        return (inst == 1) ? 3 - lane : lane;
    endfunction

    function automatic logic [7:0] exp_rd(input int inst, input int a);
        if (a >= 4*NCPU) return 8'h00;
        return em[inst][a/4][port_of(inst, a%4)];
    endfunction

    function automatic logic [NCPU-1:0] exp_irq(input int inst, input logic [31:0] st);
        logic [NCPU-1:0] r;
        for (int c = 0; c < NCPU; c++) begin
            r[c] = 1'b0;
            for (int p = 0; p < 4; p++)
                r[c] = r[c] | (|(st[8*p +: 8] & em[inst][c][p]));
        end
        return r;
    endfunction

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; acc_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4*NCPU) begin
            em[0][a/4][port_of(0, a%4)] = d;
            em[1][a/4][port_of(1, a%4)] = d;
        end
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < NADDR; a++) begin
            acc_addr = AW'(a);
            #1;
            chk(rd_n == exp_rd(0, a), {req, " normal read"}, rd_n, exp_rd(0, a));
            chk(rd_r == exp_rd(1, a), {req, " reversed read"}, rd_r, exp_rd(1, a));
        end
    endtask

    // drive status, confirm output held before the edge, then sample after
    task automatic route(input logic [31:0] st, input string req);
        logic [NCPU-1:0] old_n, old_r;
        @(negedge clk);
        old_n = irq_n; old_r = irq_r;
        pin_status = st;
        #1;
        chk(irq_n == old_n, "R2 held before edge", irq_n, old_n);
        @(negedge clk);
        chk(irq_n == exp_irq(0, st), {req, " normal irq"}, irq_n, exp_irq(0, st));
        chk(irq_r == exp_irq(1, st), {req, " reversed irq"}, irq_r, exp_irq(1, st));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        rst = 1'b1; pin_status = '0; wr_en = 1'b0; acc_addr = '0; wr_data = '0;
        for (int i = 0; i < 2; i++)
            for (int c = 0; c < NCPU; c++)
                for (int p = 0; p < 4; p++) em[i][c][p] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(irq_n == '0, "R1 normal irq reset", irq_n, 0);
        chk(irq_r == '0, "R1 reversed irq reset", irq_r, 0);
        read_all("R1 R7");

        // R8: fully open masks pass every pin to every processor
        for (int pin = 0; pin < 32; pin += 5) route(32'h1 << pin, "R8 open");

        // R5 R6: write each populated byte, read back whole window after each
        for (int a = 0; a < 4*NCPU; a++) begin
            do_write(a, 8'((a * 8'h37) ^ 8'hA5) | 8'(1 << (a % 8)));
            read_all("R5 R6");
        end

        // R3 R4 R8: single-pin sweep exposes lane to port mapping
        for (int pin = 0; pin < 32; pin++) route(32'h1 << pin, "R3 R4 R8 pin");

        // R8: block a whole port on processor 0 only
        do_write(0, 8'h00);
        for (int pin = 0; pin < 8; pin++) route(32'h1 << pin, "R8 block cpu0");

        // R7: writes to unpopulated offsets do nothing
        for (int a = 4*NCPU; a < NADDR; a++) do_write(a, 8'h00);
        read_all("R7");
        for (int pin = 0; pin < 32; pin += 3) route(32'h1 << pin, "R7 routing kept");

        // R2: multi-bit patterns and fall back to quiet
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            route(lfsr & (32'h1 << (i % 32) | 32'h1 << ((i * 7) % 32)), "R2 pattern");
        end
        route(32'h0, "R2 quiet");
        route(32'hFFFF_FFFF, "R2 all");
        route(32'h0, "R2 fall");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule